// File: doc/BRIEF.md
# Multiplexed Bus Splitter and Command Decoder

This block sits between a bus master whose low sixteen address bits share pins with its data, and a system side that expects separate, stable address, data and command buses. When the master raises its address strobe, the block captures the twenty address bits and the upper-byte enable from the shared lines. It keeps presenting that address until the next strobe, whatever the shared lines carry in between: status, write data or read data.

Data crosses a bidirectional buffer that is modelled as separate in, out and drive-enable signals on each side. One control selects the direction and an active-low enable opens the path; with the enable off, neither side is driven. The memory/IO select and the two active-low strobes form a three-bit code. Four values of that code produce the active-low commands for I/O read, I/O write, memory read and memory write. Every other value produces no command.

Top module: `bus_splitter`

## Requirements
- R1: While `rst_n` is low, and after reset until the first capture, `sys_addr` is 0 and `sys_hi_byte_en_n` is 1.
- R2: On a rising clock edge where `addr_strobe` is 1, `sys_addr` takes `{upper_addr_in, mux_ad_in}` and `sys_hi_byte_en_n` takes `hi_byte_en_n_in`. Both values appear directly after that edge.
- R3: On a rising clock edge where `addr_strobe` is 0, `sys_addr` and `sys_hi_byte_en_n` keep their values, whatever the shared lines carry.
- R4: With code = {`mem_sel`, `read_n`, `write_n`} (mem_sel the most significant bit), code 1 drives `io_rd_n` low, code 2 drives `io_wr_n` low, code 5 drives `mem_rd_n` low and code 6 drives `mem_wr_n` low.
- R5: At most one of the four command outputs is low at any time.
- R6: Codes 0, 3, 4 and 7 leave all four command outputs high.
- R7: With `xcvr_en_n`=0 and `to_sys`=1, `sys_data_oe`=1, `sys_data_out` equals `mux_ad_in` and `mux_ad_oe`=0.
- R8: With `xcvr_en_n`=0 and `to_sys`=0, `mux_ad_oe`=1, `mux_ad_out` equals `sys_data_in` and `sys_data_oe`=0.
- R9: With `xcvr_en_n`=1, both drive enables are 0 and both data outputs are 0, whatever the direction.
- R10: The commands and the data path respond in the same cycle as their inputs, without passing through a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_strobe | input | 1 | Address phase marker from the master |
| mux_ad_in | input | 16 | Shared address/data lines, master side value |
| upper_addr_in | input | 4 | Address bits 19..16 (status bits outside the address phase) |
| hi_byte_en_n_in | input | 1 | Active-low upper-byte enable (status outside the address phase) |
| mem_sel | input | 1 | 1 selects memory, 0 selects I/O |
| read_n | input | 1 | Active-low read strobe |
| write_n | input | 1 | Active-low write strobe |
| xcvr_en_n | input | 1 | Active-low data buffer enable |
| to_sys | input | 1 | Buffer direction: 1 toward the system bus, 0 toward the master |
| mux_ad_out | output | 16 | Read data driven back onto the shared lines |
| mux_ad_oe | output | 1 | Drive enable for the shared lines |
| sys_addr | output | 20 | Held system address |
| sys_hi_byte_en_n | output | 1 | Held upper-byte enable |
| sys_data_in | input | 16 | System data bus, value from the system side |
| sys_data_out | output | 16 | Write data driven onto the system data bus |
| sys_data_oe | output | 1 | Drive enable for the system data bus |
| io_rd_n | output | 1 | Active-low I/O read command |
| io_wr_n | output | 1 | Active-low I/O write command |
| mem_rd_n | output | 1 | Active-low memory read command |
| mem_wr_n | output | 1 | Active-low memory write command |

## Verification
The hardest case to provoke is a held address that stays intact while the shared lines change after the strobe drops. In a real bus cycle those lines carry status and then data, and a latch that stays open too long takes that value in as the address. After each capture, the stimulus keeps the strobe low and writes new, unrelated values to every shared line and status bit for several clock edges. It then compares the address outputs against the value taken at the capture.

// File: rtl/bus_splitter.sv
module bus_splitter #(
  parameter int LO_W = 16,
  parameter int HI_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_strobe,
  input  logic [LO_W-1:0]      mux_ad_in,
  input  logic [HI_W-1:0]      upper_addr_in,
  input  logic                 hi_byte_en_n_in,
  input  logic                 mem_sel,
  input  logic                 read_n,
  input  logic                 write_n,
  input  logic                 xcvr_en_n,
  input  logic                 to_sys,
  output logic [LO_W-1:0]      mux_ad_out,
  output logic                 mux_ad_oe,
  output logic [LO_W+HI_W-1:0] sys_addr,
  output logic                 sys_hi_byte_en_n,
  input  logic [LO_W-1:0]      sys_data_in,
  output logic [LO_W-1:0]      sys_data_out,
  output logic                 sys_data_oe,
  output logic                 io_rd_n,
  output logic                 io_wr_n,
  output logic                 mem_rd_n,
  output logic                 mem_wr_n
);
  localparam int AW = LO_W + HI_W;
  localparam logic [2:0] CODE_IO_RD  = 3'd1;
  localparam logic [2:0] CODE_IO_WR  = 3'd2;
  localparam logic [2:0] CODE_MEM_RD = 3'd5;
  localparam logic [2:0] CODE_MEM_WR = 3'd6;

  // address holding register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_addr         <= '0;
      sys_hi_byte_en_n <= 1'b1;
    end else if (addr_strobe) begin
      sys_addr         <= {upper_addr_in, mux_ad_in};
      sys_hi_byte_en_n <= hi_byte_en_n_in;
    end
  end

  // data buffer
  wire path_on = !xcvr_en_n;
  assign sys_data_oe  = path_on && to_sys;
  assign mux_ad_oe    = path_on && !to_sys;
  assign sys_data_out = sys_data_oe ? mux_ad_in   : '0;
  assign mux_ad_out   = mux_ad_oe   ? sys_data_in : '0;

  // command decode
  wire [2:0] code = {mem_sel, read_n, write_n};
  assign io_rd_n  = (code != CODE_IO_RD);
  assign io_wr_n  = (code != CODE_IO_WR);
  assign mem_rd_n = (code != CODE_MEM_RD);
  assign mem_wr_n = (code != CODE_MEM_WR);

  // R2: capture lands right after a strobed edge
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> (sys_addr == $past({upper_addr_in, mux_ad_in}))
                    && (sys_hi_byte_en_n == $past(hi_byte_en_n_in)));

  // R3: no strobe, no change
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_strobe |=> $stable(sys_addr) && $stable(sys_hi_byte_en_n));

  assert_one_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~io_rd_n, ~io_wr_n, ~mem_rd_n, ~mem_wr_n}));

  assert_no_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (read_n == write_n) |-> (io_rd_n && io_wr_n && mem_rd_n && mem_wr_n));

  assert_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sys_data_oe, mux_ad_oe}));

  assert_isolate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_en_n |-> (!sys_data_oe && !mux_ad_oe && sys_data_out == '0 && mux_ad_out == '0));

  initial assert (AW <= 32) else $error("address width over 32");
endmodule

// File: tb/bus_splitter_test.sv
module bus_splitter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_strobe = 1'b0;
  logic [15:0] mux_ad_in = '0;
  logic [3:0]  upper_addr_in = '0;
  logic        hi_byte_en_n_in = 1'b1;
  logic        mem_sel = 1'b0, read_n = 1'b1, write_n = 1'b1;
  logic        xcvr_en_n = 1'b1, to_sys = 1'b0;
  logic [15:0] sys_data_in = '0;
  logic [15:0] mux_ad_out, sys_data_out;
  logic        mux_ad_oe, sys_data_oe, sys_hi_byte_en_n;
  logic [19:0] sys_addr;
  logic        io_rd_n, io_wr_n, mem_rd_n, mem_wr_n;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_splitter uut (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .mux_ad_in(mux_ad_in),
    .upper_addr_in(upper_addr_in), .hi_byte_en_n_in(hi_byte_en_n_in),
    .mem_sel(mem_sel), .read_n(read_n), .write_n(write_n),
    .xcvr_en_n(xcvr_en_n), .to_sys(to_sys),
    .mux_ad_out(mux_ad_out), .mux_ad_oe(mux_ad_oe),
    .sys_addr(sys_addr), .sys_hi_byte_en_n(sys_hi_byte_en_n),
    .sys_data_in(sys_data_in), .sys_data_out(sys_data_out), .sys_data_oe(sys_data_oe),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic scramble(input int seed);
    mux_ad_in       = 16'(seed * 40503 + 17);
    upper_addr_in   = 4'(seed * 7 + 3);
    hi_byte_en_n_in = seed[1];
    sys_data_in     = 16'(seed * 3001);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] held;
    logic        held_hb;
    // R1: reset state, with a strobe present during reset
    @(negedge clk);
    addr_strobe = 1'b1; scramble(5);
    repeat (2) @(negedge clk);
    check("R1 addr in reset", 32'(sys_addr), 32'h0);
    check("R1 hbe in reset", 32'(sys_hi_byte_en_n), 32'h1);
    addr_strobe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr after reset", 32'(sys_addr), 32'h0);
    check("R1 hbe after reset", 32'(sys_hi_byte_en_n), 32'h1);

    // R2 / R3: capture then hold against churn on the shared lines
    for (int i = 0; i < 48; i++) begin
      held    = 20'(i * 196533 + 7);
      held_hb = i[0];
      addr_strobe = 1'b1;
      {upper_addr_in, mux_ad_in} = held;
      hi_byte_en_n_in = held_hb;
      @(negedge clk);
      addr_strobe = 1'b0;
      scramble(i + 100);
      #1;
      check("R2 captured addr", 32'(sys_addr), 32'(held));
      check("R2 captured hbe", 32'(sys_hi_byte_en_n), 32'(held_hb));
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        scramble(i * 13 + k);
        #1;
        check("R3 held addr", 32'(sys_addr), 32'(held));
        check("R3 held hbe", 32'(sys_hi_byte_en_n), 32'(held_hb));
      end
    end

    // R4..R10: combinational sweep, sampled between edges
    for (int code = 0; code < 8; code++) begin
      for (int en = 0; en < 2; en++) begin
        for (int dir = 0; dir < 2; dir++) begin
          for (int p = 0; p < 4; p++) begin
            logic [3:0]  exp_cmd;
            logic [15:0] pat_m, pat_s;
            @(negedge clk);
            pat_m = 16'(p * 21845 + code * 257 + 1);
            pat_s = ~16'(p * 4369 + en * 99 + dir);
            {mem_sel, read_n, write_n} = 3'(code);
            xcvr_en_n = en[0];
            to_sys = dir[0];
            mux_ad_in = pat_m;
            sys_data_in = pat_s;
            #1;
            exp_cmd = 4'b1111;
            if (code == 1) exp_cmd[0] = 1'b0;
            if (code == 2) exp_cmd[1] = 1'b0;
            if (code == 5) exp_cmd[2] = 1'b0;
            if (code == 6) exp_cmd[3] = 1'b0;
            if (exp_cmd == 4'b1111)
              check("R6 idle code", 32'({mem_wr_n, mem_rd_n, io_wr_n, io_rd_n}), 32'(exp_cmd));
            else
              check("R4 R10 command", 32'({mem_wr_n, mem_rd_n, io_wr_n, io_rd_n}), 32'(exp_cmd));
            check("R5 single command",
                  32'(((!io_rd_n) + (!io_wr_n) + (!mem_rd_n) + (!mem_wr_n)) <= 1), 32'h1);
            if (en == 1) begin
              check("R9 isolated", 32'({sys_data_oe, mux_ad_oe, sys_data_out, mux_ad_out}), 32'h0);
            end else if (dir == 1) begin
              check("R7 R10 write path", 32'({sys_data_oe, mux_ad_oe, sys_data_out}),
                    32'({1'b1, 1'b0, pat_m}));
            end else begin
              check("R8 R10 read path", 32'({sys_data_oe, mux_ad_oe, mux_ad_out}),
                    32'({1'b0, 1'b1, pat_s}));
            end
          end
        end
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule